// File: doc/BRIEF.md
# Sparse Hit-Pattern Readout Packer

This block turns one event's worth of conversion results into a compact packet of 16-bit words. It has sixteen channels, each with a 12-bit value and one bit of a hit mask. A single load strobe captures all of them. The block then sends a start tag and the hit mask as a pattern word. After that it sends one word for each channel whose hit bit is set, and it closes the packet with an end tag. Channels that were not hit produce no words at all.

Each data word is self-describing: the channel number sits in its top nibble and the conversion value fills the low twelve bits. The words leave on a valid/ready stream, and a last flag marks the end tag. While a packet is in flight the block raises busy and ignores further load strobes. A downstream consumer can stall the stream at any time without any word being dropped or altered.

Top module: `hit_packer`

## Requirements
- R1: After reset, out_valid, out_last and busy are all 0.
- R2: A load strobe while busy is 0 captures hit_mask and values, and on the next cycle out_valid is 1 with out_data = 0x7186 (start tag).
- R3: The second word of every packet is the captured hit mask, with bit n set when channel n was hit.
- R4: Exactly one data word follows for each set bit of the captured mask, in ascending channel order, and none for clear bits.
- R5: A data word carries the channel number in bits 15:12 and that channel's captured 12-bit value in bits 11:0.
- R6: Each packet ends with out_data = 0xF186 and out_last = 1; out_last is 0 on every other word.
- R7: With a zero hit mask the packet is exactly three words: 0x7186, 0x0000, 0xF186.
- R8: busy is 1 from the cycle after an accepted load until the end tag has been taken; a load while busy is 1 has no effect: it starts no packet and changes no word.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values; no word is skipped or repeated.
- R10: Changes to hit_mask and values after the load cycle do not affect the packet being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start-of-event strobe; sampled only while idle |
| hit_mask | input | 16 | Per-channel hit flags, bit n for channel n |
| values | input | 192 | Conversion results, channel n in bits 12n+11:12n |
| busy | output | 1 | A packet is in progress; loads are refused |
| out_data | output | 16 | Stream word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_last | output | 1 | Current word is the end tag |

## Verification
A corrupted remaining-channel mask shows up at the ports as a missing, duplicated or out-of-order data word. It appears at the first data-word handshake after the fault, and the word count at the end tag is then also wrong. A state register that slips shows up as a misplaced tag or as last on the wrong word, and a capture that leaks later inputs gives data words that do not match the values presented at load. An accepted load that should have been refused shows up as a stray start tag in the cycles right after the end tag.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_PAT,
    ST_DATA,
    ST_END
  } hp_state_t;
endpackage

// File: rtl/hp_capture.sv
module hp_capture #(
  parameter int NCH = 16,
  parameter int VW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [NCH-1:0]    hit_mask,
  input  logic [NCH*VW-1:0] values,
  input  logic [CW-1:0]     rd_idx,
  output logic [NCH-1:0]    cap_mask,
  output logic [VW-1:0]     rd_val
);
  logic [VW-1:0] val_mem [NCH];

  always_ff @(posedge clk) begin
    if (rst) cap_mask <= '0;
    else if (load_en) cap_mask <= hit_mask;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load_en) val_mem[ch] <= values[ch*VW +: VW];
    end
  end

  assign rd_val = val_mem[rd_idx];
endmodule

// File: rtl/hp_pick.sv
module hp_pick #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  output logic           found,
  output logic [CW-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = CW'(i);
      end
    end
  end
endmodule

// File: rtl/hit_packer.sv
module hit_packer #(
  parameter int          NCH       = 16,
  parameter int          VW        = 12,
  parameter int          WW        = 16,
  parameter logic [15:0] START_TAG = 16'h7186,
  parameter logic [15:0] END_TAG   = 16'hF186,
  localparam int         CW        = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NCH-1:0]    hit_mask,
  input  logic [NCH*VW-1:0] values,
  output logic              busy,
  output logic [WW-1:0]     out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last
);
  import hp_pkg::*;

  hp_state_t      state;
  logic [NCH-1:0] rem;
  logic [NCH-1:0] cap_mask;
  logic [VW-1:0]  rd_val;
  logic           found;
  logic [CW-1:0]  idx;
  logic           load_en;
  logic [WW-1:0]  pat_word;
  logic [WW-1:0]  data_word;

  assign busy    = (state != ST_IDLE);
  assign load_en = load && (state == ST_IDLE);

  hp_capture #(.NCH(NCH), .VW(VW)) u_cap (
    .clk(clk), .rst(rst), .load_en(load_en), .hit_mask(hit_mask),
    .values(values), .rd_idx(idx), .cap_mask(cap_mask), .rd_val(rd_val)
  );

  hp_pick #(.NCH(NCH)) u_pick (.mask(rem), .found(found), .idx(idx));

  always_comb begin
    pat_word = '0;
    pat_word[NCH-1:0] = cap_mask;
    data_word = '0;
    data_word[VW-1:0] = rd_val;
    data_word[WW-1 -: CW] = idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      rem       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          state     <= ST_TAG;
          out_valid <= 1'b1;
          out_last  <= 1'b0;
          out_data  <= WW'(START_TAG);
          rem       <= hit_mask;
        end
        ST_TAG: if (out_ready) begin
          state    <= ST_PAT;
          out_data <= pat_word;
        end
        ST_PAT, ST_DATA: if (out_ready) begin
          if (found) begin
            state    <= ST_DATA;
            out_data <= data_word;
            rem[idx] <= 1'b0;
          end else begin
            state    <= ST_END;
            out_data <= WW'(END_TAG);
            out_last <= 1'b1;
          end
        end
        ST_END: if (out_ready) begin
          state     <= ST_IDLE;
          out_valid <= 1'b0;
          out_last  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    load && !busy |=> out_valid && out_data == WW'(START_TAG));

  assert_hit_only_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) && out_valid |-> cap_mask[out_data[WW-1 -: CW]]);

  assert_last_tag_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> out_data == WW'(END_TAG));

  assert_refuse_R8: assert property (@(posedge clk) disable iff (rst)
    load && busy |=> $stable(cap_mask));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: tb/hit_packer_test.sv
module hit_packer_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [15:0]  hit_mask = '0;
  logic [191:0] values = '0;
  logic         busy;
  logic [15:0]  out_data;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic         out_last;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_w [0:18];
  int exp_n;

  always #4 clk = ~clk;

  hit_packer uut (
    .clk(clk), .rst(rst), .load(load), .hit_mask(hit_mask), .values(values),
    .busy(busy), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic void build_expected(input logic [15:0] m, input logic [191:0] v);
    exp_n = 0;
    exp_w[exp_n++] = 16'h7186;
    exp_w[exp_n++] = m;
    for (int ch = 0; ch < 16; ch++)
      if (m[ch]) exp_w[exp_n++] = {4'(ch), v[ch*12 +: 12]};
    exp_w[exp_n++] = 16'hF186;
  endfunction

  function automatic string word_req(input int i, input int n);
    if (i == 0) return "R2";
    if (n == 3) return "R7";
    if (i == 1) return "R3";
    if (i == n - 1) return "R6";
    return "R4/R5";
  endfunction

  task automatic run_packet(input logic [15:0] m, input int stall_pct, input bit inject);
    logic [191:0] v;
    logic [15:0] held;
    bit hold_pending;
    int idx;
    int guard;
    for (int ch = 0; ch < 16; ch++) v[ch*12 +: 12] = 12'($urandom);
    build_expected(m, v);
    @(negedge clk);
    chk(busy == 1'b0, "R8 idle before load", 16'(busy), 16'h0);
    hit_mask = m; values = v; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(busy == 1'b1, "R8 busy after load", 16'(busy), 16'h1);
    // R10: scramble the inputs once the load has been taken
    hit_mask = 16'($urandom);
    for (int ch = 0; ch < 16; ch++) values[ch*12 +: 12] = 12'($urandom);
    idx = 0; guard = 0; hold_pending = 0; held = '0;
    while (idx < exp_n && guard < 2000) begin
      if (hold_pending)
        chk(out_valid && out_data == held, "R9 hold", out_data, held);
      if (inject) begin
        load = ($urandom % 4) == 0;   // R8: refused loads
        hit_mask = 16'($urandom);
      end
      out_ready = ($urandom % 100) >= stall_pct;
      if (out_valid && out_ready) begin
        chk(out_data == exp_w[idx], word_req(idx, exp_n), out_data, exp_w[idx]);
        chk(out_last == (idx == exp_n - 1), "R6 last flag", 16'(out_last),
            16'(idx == exp_n - 1));
        idx++;
        hold_pending = 0;
      end else if (out_valid) begin
        hold_pending = 1;
        held = out_data;
      end
      @(negedge clk);
      guard++;
    end
    chk(idx == exp_n, "R4 word count", 16'(idx), 16'(exp_n));
    load = 1'b0;
    out_ready = 1'b1;
    chk(busy == 1'b0, "R8 busy clears", 16'(busy), 16'h0);
    chk(out_valid == 1'b0, "R8 no stray packet", 16'(out_valid), 16'h0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 still idle", 16'(out_valid), 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", 16'(out_valid), 16'h0);
    chk(busy == 1'b0, "R1 busy", 16'(busy), 16'h0);
    chk(out_last == 1'b0, "R1 last", 16'(out_last), 16'h0);
    rst = 1'b0;
    run_packet(16'h0000, 0, 0);    // R7
    run_packet(16'h0000, 60, 1);   // R7 with stalls and refused loads
    run_packet(16'hFFFF, 0, 0);    // R4 all channels
    run_packet(16'h8001, 50, 1);   // R4 end channels
    run_packet(16'h0001, 90, 0);   // R9 heavy stall
    run_packet(16'h8000, 30, 1);
    for (int n = 0; n < 40; n++)
      run_packet(16'($urandom), int'($urandom % 70), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule